// File: doc/BRIEF.md
# Port and Interrupt Flag Register Slice with Bit-Operation Read Steering

This block is a small memory-mapped register slice for an 8-bit peripheral bus. It holds three registers: a general-purpose I/O port (an output latch plus a per-bit direction register) and one byte that carries interrupt request flags in its low half and their enable bits in its high half. Hardware event pulses set the flags. Software clears a flag by writing 0 to its bit, and the block raises a single interrupt request whenever an enabled flag is pending.

The read path is steered by a read-modify-write indicator that the bus master raises during the read phase of a single-bit set or clear instruction. In that phase the port address returns the output latch instead of the pin levels. The flag bits also return all ones. The master then writes the byte back with one bit changed, and no neighbouring latch bit or pending flag is disturbed. This holds whatever the pin directions or the levels on the pins. Read data is combinational from the address and strobes, and writes take effect at the next rising clock edge.

Top module: `rmw_port_irq_regs`

## Requirements
- R1: After reset the latch, the direction register, the flags and the enables are all zero, pin_oe is 0 and irq_req is 0.
- R2: A read of the port address (0x0) with rmw low returns pin_in.
- R3: A read of the port address with rmw high returns the output latch, not pin_in.
- R4: A write to the port address loads the latch at the next edge. Bit i of pin_out equals latch bit i when direction bit i is 1 and is 0 otherwise, and pin_oe equals the direction register.
- R5: The direction register at address 0x1 is written and read back as a whole byte, with 1 meaning output.
- R6: A read of the flag address (0x2) with rmw low returns the enables in bits [7:4] and the flags in bits [3:0].
- R7: A read of the flag address with rmw high returns 1 in every flag bit [3:0] and the true enables in [7:4].
- R8: A write to the flag address clears flag i when data bit i is 0 and leaves it unchanged when the bit is 1; bits [7:4] load the enables. A flag never becomes set without an event.
- R9: An event pulse on irq_evt[i] sets flag i at the next edge, even when a write clears that bit in the same cycle.
- R10: irq_req is 1 exactly when some flag and its enable bit are both 1.
- R11: rd_data is 0 when rd_en is low or the address maps to no register.
- R12: An rmw read followed by a write back of that byte with one bit changed alters only that bit, for both the latch and the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rmw | input | 1 | High during the read phase of a bit operation |
| rd_data | output | 8 | Read data, combinational |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Value driven onto the pins |
| pin_oe | output | 8 | Per-pin output enable |
| irq_evt | input | 4 | Hardware event pulses, one per flag |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The port is read with pin levels that differ from the latch in every pattern. A normal read and an rmw read of the same cycle state must therefore return different bytes, which shows which source the steering picked. Flag bytes are read in both modes while some flags are set and others clear, so the forced ones in an rmw read are told apart from real pending state. Clears are tried with and without a same-cycle event on the cleared bit and on its neighbours. A set-bit sequence is played through both registers, with pins opposed to the latch and with pending flags, to show that the write-back keeps every other bit.

// File: rtl/rmw_regs_pkg.sv
package rmw_regs_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PORT = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_IRQ  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/rmw_addr_decode.sv
module rmw_addr_decode
    import rmw_regs_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int PORT_ADDR = 0,
    parameter int DIR_ADDR  = 1,
    parameter int IRQ_ADDR  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if (addr == ADDR_W'(PORT_ADDR))      sel = SEL_PORT;
        else if (addr == ADDR_W'(DIR_ADDR))  sel = SEL_DIR;
        else if (addr == ADDR_W'(IRQ_ADDR))  sel = SEL_IRQ;
        else                                 sel = SEL_NONE;
    end
endmodule

// File: rtl/rmw_port_slice.sv
module rmw_port_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_latch,
    input  logic         wr_dir,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] dir;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_latch) st_d.latch = wr_data;
        if (wr_dir)   st_d.dir   = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_q = st_q.latch;
    assign dir_q   = st_q.dir;
    assign pin_oe  = st_q.dir;

    for (genvar i = 0; i < W; i++) begin : g_pin_drive
        assign pin_out[i] = st_q.dir[i] ? st_q.latch[i] : 1'b0;
    end

    // R4: latch changes only through a write
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_latch |=> $stable(latch_q));
    // R4: a write lands in the latch at the next edge
    p_latch_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch |=> (latch_q == $past(wr_data)));
    // R5: direction register loads on its write
    p_dir_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == $past(wr_data)));
endmodule

// File: rtl/rmw_irq_slice.sv
module rmw_irq_slice #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] wr_keep,
    input  logic [N-1:0] wr_enables,
    input  logic [N-1:0] evt,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] enables_q,
    output logic         irq_req
);
    typedef struct packed {
        logic [N-1:0] flags;
        logic [N-1:0] enables;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.flags   = st_q.flags & wr_keep;
            st_d.enables = wr_enables;
        end
        // events override a same-cycle clear
        st_d.flags = st_d.flags | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q   = st_q.flags;
    assign enables_q = st_q.enables;
    assign irq_req   = |(st_q.flags & st_q.enables);

    // R9: every event bit is set one edge later
    p_event_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags_q & $past(evt)) == $past(evt)));
    // R8: a flag never rises without an event
    p_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_n || ((flags_q & ~$past(flags_q) & ~$past(evt)) == '0));
    // R8: without a write, flags only gain bits
    p_no_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    // R10: request rises only after a write or an event
    p_req_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ($past(wr) || ($past(evt) != '0)));
endmodule

// File: rtl/rmw_port_irq_regs.sv
module rmw_port_irq_regs
    import rmw_regs_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int PORT_ADDR = 0,
    parameter int DIR_ADDR  = 1,
    parameter int IRQ_ADDR  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rmw,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe,
    input  logic [DATA_W/2-1:0] irq_evt,
    output logic              irq_req
);
    localparam int N_IRQ = DATA_W / 2;

    reg_sel_e          sel;
    logic [DATA_W-1:0] latch_q, dir_q;
    logic [N_IRQ-1:0]  flags_q, enables_q;
    logic [DATA_W-1:0] rd_d;

    rmw_addr_decode #(
        .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR),
        .DIR_ADDR(DIR_ADDR), .IRQ_ADDR(IRQ_ADDR)
    ) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    rmw_port_slice #(.W(DATA_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_latch (wr_en && (sel == SEL_PORT)),
        .wr_dir   (wr_en && (sel == SEL_DIR)),
        .wr_data  (wr_data),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    rmw_irq_slice #(.N(N_IRQ)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_en && (sel == SEL_IRQ)),
        .wr_keep    (wr_data[N_IRQ-1:0]),
        .wr_enables (wr_data[DATA_W-1:N_IRQ]),
        .evt        (irq_evt),
        .flags_q    (flags_q),
        .enables_q  (enables_q),
        .irq_req    (irq_req)
    );

    // read steering: rmw phase substitutes latch and forced flag ones
    always_comb begin
        rd_d = '0;
        unique case (sel)
            SEL_PORT: rd_d = rmw ? latch_q : pin_in;
            SEL_DIR:  rd_d = dir_q;
            SEL_IRQ:  rd_d = {enables_q, (rmw ? {N_IRQ{1'b1}} : flags_q)};
            default:  rd_d = '0;
        endcase
        if (!rd_en) rd_d = '0;
    end

    assign rd_data = rd_d;

    // R3: rmw read of the port sees the latch
    p_rmw_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rmw && addr == ADDR_W'(PORT_ADDR)) |-> (rd_data == latch_q));
    // R2: normal read of the port sees the pins
    p_norm_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rmw && addr == ADDR_W'(PORT_ADDR)) |-> (rd_data == pin_in));
    // R7: rmw read of the flag byte forces ones in the flag half
    p_rmw_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rmw && addr == ADDR_W'(IRQ_ADDR))
            |-> (rd_data[N_IRQ-1:0] == {N_IRQ{1'b1}}));
    // R11: idle or unmapped reads return zero
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || sel == SEL_NONE) |-> (rd_data == '0));
endmodule

// File: tb/rmw_port_irq_regs_tb.sv
module rmw_port_irq_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       rmw = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic [3:0] irq_evt = '0;
    logic       irq_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    rmw_port_irq_regs u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rmw(rmw), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_evt(irq_evt), .irq_req(irq_req)
    );

    always #10 clk = ~clk;  // 50 MHz

    // is_rd, addr, data, rmw, pin, evt, expected read
    typedef struct packed {
        logic       is_rd;
        logic [3:0] a;
        logic [7:0] d;
        logic       m;
        logic [7:0] p;
        logic [3:0] e;
        logic [7:0] x;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'h1, 8'h0F, 1'b0, 8'h00, 4'h0, 8'h00}, // dir
        '{1'b0, 4'h0, 8'hA5, 1'b0, 8'h00, 4'h0, 8'h00}, // latch
        '{1'b1, 4'h0, 8'h00, 1'b0, 8'h3C, 4'h0, 8'h3C}, // R2
        '{1'b1, 4'h0, 8'h00, 1'b1, 8'h3C, 4'h0, 8'hA5}, // R3
        '{1'b1, 4'h1, 8'h00, 1'b0, 8'h00, 4'h0, 8'h0F}, // R5
        '{1'b1, 4'h0, 8'h00, 1'b0, 8'hFF, 4'h0, 8'hFF}, // R2
        '{1'b1, 4'h0, 8'h00, 1'b1, 8'h5A, 4'h0, 8'hA5}, // R3
        '{1'b0, 4'h2, 8'hF0, 1'b0, 8'h00, 4'h0, 8'h00},
        '{1'b1, 4'h2, 8'h00, 1'b0, 8'h00, 4'h0, 8'hF0}, // R6
        '{1'b1, 4'h2, 8'h00, 1'b1, 8'h00, 4'h0, 8'hFF}, // R7
        '{1'b0, 4'h2, 8'h30, 1'b0, 8'h00, 4'h5, 8'h00}, // R9 set
        '{1'b1, 4'h2, 8'h00, 1'b0, 8'h00, 4'h0, 8'h35}, // R6 R9
        '{1'b1, 4'h2, 8'h00, 1'b1, 8'h00, 4'h0, 8'h3F}, // R7
        '{1'b0, 4'h2, 8'h3E, 1'b0, 8'h00, 4'h0, 8'h00}, // R8 clear bit0
        '{1'b1, 4'h2, 8'h00, 1'b0, 8'h00, 4'h0, 8'h34}, // R8
        '{1'b0, 4'h2, 8'h30, 1'b0, 8'h00, 4'h4, 8'h00}, // R9 clash
        '{1'b1, 4'h2, 8'h00, 1'b0, 8'h00, 4'h0, 8'h34}, // R9
        '{1'b1, 4'h5, 8'h00, 1'b1, 8'hFF, 4'h0, 8'h00}  // R11
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // drive at negedge, sample 5 ns later, commit at following posedge
    task automatic cyc(input logic r, input logic [3:0] a, input logic [7:0] d,
                       input logic m, input logic [7:0] p, input logic [3:0] e);
        @(negedge clk);
        addr = a; wr_en = !r; rd_en = r; wr_data = d; rmw = m; pin_in = p; irq_evt = e;
        #5;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; rmw = 1'b0; irq_evt = '0;
        #5;
    endtask

    initial begin
        logic [7:0] got;
        repeat (3) @(posedge clk);
        // R1 reset state
        cyc(1'b1, 4'h1, 8'h00, 1'b0, 8'h00, 4'h0);
        check("R1 dir", rd_data, 8'h00);
        cyc(1'b1, 4'h2, 8'h00, 1'b0, 8'h00, 4'h0);
        check("R1 irq", rd_data, 8'h00);
        check("R1 oe", pin_oe, 8'h00);
        check("R1 req", {7'd0, irq_req}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].is_rd, VECS[i].a, VECS[i].d, VECS[i].m, VECS[i].p, VECS[i].e);
            if (VECS[i].is_rd) check($sformatf("vec%0d", i), rd_data, VECS[i].x);
        end
        idle();

        // R11: strobe low gives zero
        cyc(1'b1, 4'h0, 8'h00, 1'b1, 8'hFF, 4'h0);
        rd_en = 1'b0; #1;
        check("R11 idle", rd_data, 8'h00);

        // R4: latch A5 dir 0F
        check("R4 pin_out", pin_out, 8'h05);
        check("R4 pin_oe", pin_oe, 8'h0F);

        // R10: enables 3, flag2 pending -> no request; enable 2 -> request
        check("R10 off", {7'd0, irq_req}, 8'h00);
        cyc(1'b0, 4'h2, 8'h44, 1'b0, 8'h00, 4'h0);
        idle();
        check("R10 on", {7'd0, irq_req}, 8'h01);
        cyc(1'b0, 4'h2, 8'h40, 1'b0, 8'h00, 4'h0);
        idle();
        check("R10 cleared", {7'd0, irq_req}, 8'h00);

        // R12: set port bit 6 with pins opposed
        cyc(1'b1, 4'h0, 8'h00, 1'b1, 8'h5A, 4'h0);
        got = rd_data;
        cyc(1'b0, 4'h0, got | 8'h40, 1'b0, 8'h5A, 4'h0);
        cyc(1'b1, 4'h0, 8'h00, 1'b1, 8'h00, 4'h0);
        check("R12 port", rd_data, 8'hE5);

        // R12: flags 1 and 3 pending, set enable bit 5 by bit op
        cyc(1'b0, 4'h2, 8'h00, 1'b0, 8'h00, 4'hA);
        cyc(1'b1, 4'h2, 8'h00, 1'b1, 8'h00, 4'h0);
        got = rd_data;
        cyc(1'b0, 4'h2, got | 8'h20, 1'b0, 8'h00, 4'h0);
        cyc(1'b1, 4'h2, 8'h00, 1'b0, 8'h00, 4'h0);
        check("R12 flags", rd_data, 8'h2A);
        check("R10 req", {7'd0, irq_req}, 8'h01);
        idle();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (5000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule